// File: doc/BRIEF.md
# Fault-to-Break Routing Lock Register

This block is one memory-mapped configuration word that decides which of four fault sources may stop the timers through a shared break line. The sources are a processor lockup signal, an on-chip RAM parity error, a voltage-detector interrupt and a flash ECC error. Each source has its own routing bit. Software can set a routing bit, but software can never clear it. Only a system reset returns it to zero. A set routing bit therefore both connects its source and locks that connection in place.

The same word holds a parity error flag. Hardware raises the flag whenever the RAM reports a parity error, whatever the routing bits say. Software drops the flag by writing a one to it. The routing bit for the voltage detector has a second job: while it is set, the block asserts an output that makes the detector's enable and its three-bit level select in the power controller read-only.

Each routing bit is a two-state machine. LK_OPEN goes to LK_HELD on a write of one to that bit, and LK_HELD holds until reset. The flag is a two-state machine. FL_IDLE goes to FL_RAISED on a parity event. FL_RAISED goes back to FL_IDLE on a write-one clear, but only when no parity event arrives in the same cycle.

Top module: `brk_src_lock`

## Requirements
- R1: After reset, the register reads 0x0000_0000, `brk_out` is 0 and `vdet_cfg_frozen` is 0.
- R2: Bits 31:9 and 7:4 always read as zero. Writing ones to them changes no readable bit and no output.
- R3: A write of 1 at offset 0x1C sets the routing bits. Bit 0 routes processor lockup, bit 1 routes RAM parity, bit 2 routes the voltage detector and bit 3 routes flash ECC. The new value is visible from the next cycle. Writing 0 never clears a routing bit; only reset does.
- R4: A write to any address other than 0x1C changes nothing in this register.
- R5: A parity event on `flt_ram_parity` sets the flag at bit 8 in the next cycle, whether or not routing bit 1 is set.
- R6: Writing 1 to bit 8 clears the flag in the next cycle. Writing 0 to bit 8 leaves the flag unchanged.
- R7: If a parity event and a write-one clear arrive in the same cycle, the flag is 1 afterwards.
- R8: `brk_out` is the OR of every fault input whose routing bit is set. It follows the inputs in the same cycle, with no register in the path.
- R9: `vdet_cfg_frozen` equals routing bit 2.
- R10: A read at offset 0x1C returns the flag and the routing bits and has no side effects. Any other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| flt_lockup | input | 1 | Processor lockup fault |
| flt_ram_parity | input | 1 | RAM parity error event |
| flt_vdet | input | 1 | Voltage-detector interrupt |
| flt_ecc | input | 1 | Flash ECC error |
| brk_out | output | 1 | Combined timer break request |
| vdet_cfg_frozen | output | 1 | Freezes voltage-detector settings elsewhere |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the register at offset 0x1C. With these values the neighbouring word at 0x18 can be written, which tests that other addresses are ignored. They also let a full 32-bit pattern reach every reserved bit. A behavioural model checks every cycle. It covers routing bits set one at a time and all together, attempts to clear them, and the case where a parity event and a clear arrive in the same cycle. A second reset then shows that only reset releases the locks.

// File: rtl/brk_lock_pkg.sv
package brk_lock_pkg;
    localparam int NUM_SRC  = 4;
    localparam int FLAG_BIT = 8;
    localparam int SRC_LOCKUP = 0;
    localparam int SRC_PARITY = 1;
    localparam int SRC_VDET   = 2;
    localparam int SRC_ECC    = 3;

    typedef enum logic {LK_OPEN, LK_HELD} lock_state_e;
    typedef enum logic {FL_IDLE, FL_RAISED} flag_state_e;
endpackage

// File: rtl/brk_lock_cell.sv
module brk_lock_cell
    import brk_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic locked
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (set_req) state_d = LK_HELD;
            LK_HELD: state_d = LK_HELD;
            default: state_d = LK_OPEN;
        endcase
    end

    always_comb locked = (state_q == LK_HELD);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    // R3
    lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> locked);
endmodule

// File: rtl/brk_err_flag.sv
module brk_err_flag
    import brk_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt,
    input  logic sw_clr,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:   if (hw_evt) state_d = FL_RAISED;
            FL_RAISED: if (sw_clr && !hw_evt) state_d = FL_IDLE;
            default:   state_d = FL_IDLE;
        endcase
    end

    always_comb flag = (state_q == FL_RAISED);

    // R5 R7
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> flag);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !hw_evt) |=> !flag);
    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_clr && !hw_evt) |=> (flag == $past(flag)));
endmodule

// File: rtl/brk_fault_merge.sv
module brk_fault_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] route_en,
    input  logic [N-1:0] src,
    output logic         brk
);
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = route_en[i] & src[i];
    end

    assign brk = |gated;

    // R8
    always_comb begin
        merge_none_chk: assert (!(route_en == '0 && brk));
    end
endmodule

// File: rtl/brk_src_lock.sv
module brk_src_lock
    import brk_lock_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 32,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              flt_lockup,
    input  logic              flt_ram_parity,
    input  logic              flt_vdet,
    input  logic              flt_ecc,
    output logic              brk_out,
    output logic              vdet_cfg_frozen
);
    localparam int RSV_HI = DATA_W - 1;

    logic               hit_wr;
    logic [NUM_SRC-1:0] locks;
    logic [NUM_SRC-1:0] srcs;
    logic               perr_flag;
    logic               unused_wdata;

    assign hit_wr = bus_wr && (bus_addr == REG_OFS);
    assign unused_wdata = ^{bus_wdata[RSV_HI:FLAG_BIT+1], bus_wdata[FLAG_BIT-1:NUM_SRC]};

    always_comb begin
        srcs = '0;
        srcs[SRC_LOCKUP] = flt_lockup;
        srcs[SRC_PARITY] = flt_ram_parity;
        srcs[SRC_VDET]   = flt_vdet;
        srcs[SRC_ECC]    = flt_ecc;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lock
        brk_lock_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (hit_wr && bus_wdata[i]),
            .locked  (locks[i])
        );
    end

    brk_err_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_evt (flt_ram_parity),
        .sw_clr (hit_wr && bus_wdata[FLAG_BIT]),
        .flag   (perr_flag)
    );

    brk_fault_merge #(.N(NUM_SRC)) u_merge (
        .route_en (locks),
        .src      (srcs),
        .brk      (brk_out)
    );

    assign vdet_cfg_frozen = locks[SRC_VDET];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG_OFS) begin
            bus_rdata[NUM_SRC-1:0] = locks;
            bus_rdata[FLAG_BIT]    = perr_flag;
        end
    end

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[RSV_HI:FLAG_BIT+1] == '0) && (bus_rdata[FLAG_BIT-1:NUM_SRC] == '0));
    // R4
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != REG_OFS && !flt_ram_parity) |=> $stable(locks) && $stable(perr_flag));
    // R9
    frozen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vdet_cfg_frozen |=> vdet_cfg_frozen);
endmodule

// File: tb/brk_src_lock_bench.sv
module brk_src_lock_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [3:0]  flt = 0;
    logic        brk_out, vdet_cfg_frozen;

    int total = 0, bad = 0;
    int m_lock[4];
    int m_flag;

    always #5 clk = ~clk;

    brk_src_lock u_brk_src_lock (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flt_lockup(flt[0]), .flt_ram_parity(flt[1]), .flt_vdet(flt[2]), .flt_ecc(flt[3]),
        .brk_out(brk_out), .vdet_cfg_frozen(vdet_cfg_frozen)
    );

    task automatic check(string tag);
        logic [31:0] exp_rd;
        logic exp_brk;
        exp_rd = 0;
        exp_brk = 0;
        if (bus_addr == 8'h1C) begin
            for (int i = 0; i < 4; i++) exp_rd[i] = (m_lock[i] != 0);
            exp_rd[8] = (m_flag != 0);
        end
        for (int i = 0; i < 4; i++) if (m_lock[i] != 0 && flt[i]) exp_brk = 1;
        total++;
        if (bus_rdata !== exp_rd) begin
            bad++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, exp_rd);
        end
        if (brk_out !== exp_brk) begin
            bad++;
            $display("FAIL %s brk_out actual=%b expected=%b", tag, brk_out, exp_brk);
        end
        if (vdet_cfg_frozen !== (m_lock[2] != 0)) begin
            bad++;
            $display("FAIL %s frozen actual=%b expected=%b", tag, vdet_cfg_frozen, m_lock[2] != 0);
        end
    endtask

    task automatic cyc(string tag, logic rn, logic [7:0] a, logic w, logic [31:0] d, logic [3:0] f);
        @(negedge clk);
        rst_n = rn; bus_addr = a; bus_wr = w; bus_wdata = d; flt = f;
        if (!rn) begin
            for (int i = 0; i < 4; i++) m_lock[i] = 0;
            m_flag = 0;
        end
        #1 check(tag);
        @(posedge clk);
        if (rn) begin
            if (f[1]) m_flag = 1;
            else if (w && a == 8'h1C && d[8]) m_flag = 0;
            if (w && a == 8'h1C)
                for (int i = 0; i < 4; i++) if (d[i]) m_lock[i] = 1;
        end
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_lock[i] = 0;
        m_flag = 0;
        cyc("R1", 0, 8'h1C, 0, 0, 4'h0);
        cyc("R1", 0, 8'h1C, 0, 0, 4'hF);
        cyc("R1", 1, 8'h1C, 0, 0, 4'h0);
        cyc("R8", 1, 8'h1C, 0, 0, 4'hF);
        cyc("R5", 1, 8'h1C, 0, 0, 4'h2);
        cyc("R5", 1, 8'h1C, 0, 0, 4'h0);
        cyc("R6", 1, 8'h1C, 1, 32'h0000_0000, 4'h0);
        cyc("R6", 1, 8'h1C, 1, 32'h0000_0100, 4'h0);
        cyc("R6", 1, 8'h1C, 0, 0, 4'h0);
        cyc("R7", 1, 8'h1C, 1, 32'h0000_0100, 4'h2);
        cyc("R7", 1, 8'h1C, 0, 0, 4'h0);
        cyc("R2", 1, 8'h1C, 1, 32'hFFFF_FEF0, 4'h0);
        cyc("R2", 1, 8'h1C, 0, 0, 4'hF);
        cyc("R4", 1, 8'h18, 1, 32'hFFFF_FFFF, 4'h0);
        cyc("R4", 1, 8'h1C, 0, 0, 4'hF);
        cyc("R3", 1, 8'h1C, 1, 32'h0000_0001, 4'h0);
        cyc("R3", 1, 8'h1C, 1, 32'h0000_0000, 4'h1);
        cyc("R8", 1, 8'h1C, 0, 0, 4'hE);
        cyc("R8", 1, 8'h1C, 0, 0, 4'h1);
        cyc("R9", 1, 8'h1C, 1, 32'h0000_0004, 4'h0);
        cyc("R9", 1, 8'h1C, 0, 0, 4'h4);
        cyc("R8", 1, 8'h1C, 0, 0, 4'hA);
        cyc("R3", 1, 8'h1C, 1, 32'h0000_000A, 4'h0);
        cyc("R3", 1, 8'h1C, 1, 32'h0000_0000, 4'h0);
        for (int p = 0; p < 16; p++) cyc("R8", 1, 8'h1C, 0, 0, p[3:0]);
        cyc("R10", 1, 8'h1C, 0, 0, 4'h0);
        cyc("R10", 1, 8'h1C, 0, 0, 4'h0);
        cyc("R10", 1, 8'h20, 0, 0, 4'h0);
        cyc("R10", 1, 8'h1C, 0, 0, 4'h2);
        cyc("R1", 0, 8'h1C, 0, 0, 4'hF);
        cyc("R1", 1, 8'h1C, 0, 0, 4'hF);
        cyc("R3", 1, 8'h1C, 1, 32'h0000_0008, 4'h8);
        cyc("R8", 1, 8'h1C, 0, 0, 4'h8);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule